// File: doc/BRIEF.md
# Serial link training controller: receiver detect and polling

This block sequences the early bring-up of a multi-lane serial link. After reset it waits a fixed quiet interval, checks once that every lane sees a receiver, and then enters polling. While polling it tells the transmit side which training set to send: TS1 while polling for the partner, TS2 while agreeing on configuration, or a compliance pattern. The choice is a symbolic code, not encoded symbols. It counts the training sets it sends and the sets that arrive on all lanes at once. When both counts reach their targets it moves on, and in the configuration stage it raises a flag that hands the link to the later stages.

Each polling stage has a timeout. When the active polling timeout expires, the machine normally goes back to the quiet state, so a partner that never answers makes the machine cycle through quiet, detect and polling without end. A force-compliance control input turns that timeout into entry to the compliance state instead. The current state is always visible as a fixed numeric code on a debug output.

Top module: `link_train_fsm`

## Requirements
- R1: The debug state output carries 0 for quiet, 1 for active detect, 2 for active polling, 3 for compliance and 4 for configuration. A synchronous active-high reset gives code 0, transmit selector 0 and a low flag on the next clock.
- R2: The machine stays in quiet for exactly QUIET_CYCLES clocks and then enters active detect.
- R3: Active detect lasts one clock. If every bit of the signal-detect input is 1, the next state is active polling; otherwise it is quiet.
- R4: The transmit selector is 0 (nothing) in quiet and active detect, 1 (TS1) in active polling, 2 (TS2) in configuration and 3 (compliance pattern) in compliance.
- R5: Active polling moves to configuration on the clock after both of these hold: RX_NEED consecutive receive events with the valid bit set on all lanes, and TS1_TX_NEED clocks spent sending TS1. A receive event with the valid bit set on some lanes but not all restarts the consecutive count. A clock with no valid lane leaves the count unchanged.
- R6: If the active polling timeout of POLL_TO_CYCLES clocks expires while force-compliance is 0, the machine returns to quiet and starts the detect sequence again.
- R7: If that timeout expires while force-compliance is 1, the machine enters compliance. It stays there while the bit is 1 and returns to active polling on the clock after the bit reads 0.
- R8: In configuration the flag rises on the clock after two counts are both met. The first is RX_NEED consecutive events in which all lanes are valid and all have their TS2 bit set. The second is TS2_TX_NEED TS2 sets sent, counted from the clock the first such TS2 event arrives. Once the flag is set, the machine stays in configuration with the flag held and no timeout applies.
- R9: If configuration lasts CFG_TO_CYCLES clocks without raising the flag, the machine returns to quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| force_compliance | input | 1 | Polling timeout enters compliance instead of quiet |
| rx_sigdet | input | NUM_LANES | Per-lane receiver signal detect |
| rx_ts_valid | input | NUM_LANES | Per-lane: a valid training set arrived this clock |
| rx_ts_is_ts2 | input | NUM_LANES | Per-lane: the arrived set is TS2 (else TS1) |
| dbg_state | output | 3 | Numeric state code |
| tx_set | output | 2 | Training set selector for the transmit side |
| link_cfg_up | output | 1 | Configuration complete |

## Verification
Every output is a register, or decodes a register, so each result shows up one clock after the edge that decides it. The timeouts count from the edge that entered the state. Quiet ends after QUIET_CYCLES edges, detect after one more, and the exits from polling and configuration come one edge after the last counter reaches its target. The scoreboard stores each expected value with the number of clock edges since reset release at which it is due. The monitor compares it at the falling edge after that count, and an item whose edge has passed without a comparison is reported as missed. Stimulus changes only on falling edges, so the sample point never coincides with an update.

// File: rtl/ltrn_pkg.sv
package ltrn_pkg;

   typedef enum logic [2:0] {
      ST_QUIET  = 3'd0,
      ST_DETECT = 3'd1,
      ST_POLL   = 3'd2,
      ST_COMPL  = 3'd3,
      ST_CFG    = 3'd4
   } ltrn_state_e;

   typedef enum logic [1:0] {
      TX_NONE  = 2'd0,
      TX_TS1   = 2'd1,
      TX_TS2   = 2'd2,
      TX_COMPL = 2'd3
   } ltrn_tx_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ltrn_lane_agg.sv
module ltrn_lane_agg #(
   parameter int NUM_LANES = 4
) (
   input  logic [NUM_LANES-1:0] sigdet,
   input  logic [NUM_LANES-1:0] ts_valid,
   input  logic [NUM_LANES-1:0] ts_is_ts2,
   output logic                 all_det,
   output logic                 any_rx,
   output logic                 all_rx,
   output logic                 all_ts2
);
   logic [NUM_LANES:0] det_chain, any_chain, rx_chain, ts2_chain;

   assign det_chain[0] = 1'b1;
   assign any_chain[0] = 1'b0;
   assign rx_chain[0]  = 1'b1;
   assign ts2_chain[0] = 1'b1;

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      assign det_chain[g+1] = det_chain[g] & sigdet[g];
      assign any_chain[g+1] = any_chain[g] | ts_valid[g];
      assign rx_chain[g+1]  = rx_chain[g]  & ts_valid[g];
      assign ts2_chain[g+1] = ts2_chain[g] & ts_is_ts2[g];
   end

   assign all_det = det_chain[NUM_LANES];
   assign any_rx  = any_chain[NUM_LANES];
   assign all_rx  = rx_chain[NUM_LANES];
   assign all_ts2 = ts2_chain[NUM_LANES];
endmodule

// File: rtl/ltrn_sat_cnt.sv
module ltrn_sat_cnt #(
   parameter int LIMIT = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic inc,
   input  logic miss,
   output logic done
);
   localparam int W = $clog2(LIMIT + 1);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || clr || miss)
         cnt_q <= '0;
      else if (inc && (cnt_q != W'(LIMIT)))
         cnt_q <= cnt_q + 1'b1;
   end

   assign done = (cnt_q == W'(LIMIT));
endmodule

// File: rtl/ltrn_timer.sv
module ltrn_timer #(
   parameter int MAX_CYCLES = 64,
   localparam int W = $clog2(MAX_CYCLES + 1)
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   output logic [W-1:0] value
);
   always_ff @(posedge clk) begin
      if (rst || clr)
         value <= '0;
      else if (value != W'(MAX_CYCLES))
         value <= value + 1'b1;
   end
endmodule

// File: rtl/link_train_fsm.sv
module link_train_fsm
   import ltrn_pkg::*;
#(
   parameter int NUM_LANES     = 4,
   parameter int QUIET_CYCLES  = 64,
   parameter int POLL_TO_CYCLES = 2048,
   parameter int CFG_TO_CYCLES = 4096,
   parameter int RX_NEED       = 8,
   parameter int TS1_TX_NEED   = 1024,
   parameter int TS2_TX_NEED   = 16
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 force_compliance,
   input  logic [NUM_LANES-1:0] rx_sigdet,
   input  logic [NUM_LANES-1:0] rx_ts_valid,
   input  logic [NUM_LANES-1:0] rx_ts_is_ts2,
   output logic [2:0]           dbg_state,
   output logic [1:0]           tx_set,
   output logic                 link_cfg_up
);
   localparam int TMAX = imax(QUIET_CYCLES, imax(POLL_TO_CYCLES, CFG_TO_CYCLES));
   localparam int TW   = $clog2(TMAX + 1);

   if (NUM_LANES < 1) begin : g_bad_lanes
      $error("NUM_LANES must be at least 1");
   end
   if (QUIET_CYCLES < 1 || RX_NEED < 1 || TS2_TX_NEED < 1) begin : g_bad_cnt
      $error("cycle and set counts must be at least 1");
   end
   if (POLL_TO_CYCLES <= TS1_TX_NEED) begin : g_bad_poll
      $error("POLL_TO_CYCLES must exceed TS1_TX_NEED");
   end
   if (CFG_TO_CYCLES <= TS2_TX_NEED + RX_NEED) begin : g_bad_cfg
      $error("CFG_TO_CYCLES too short for configuration");
   end

   ltrn_state_e st_q, st_d;
   logic        chg;
   logic        all_det, any_rx, all_rx, all_ts2, ts2_now;
   logic        rx_done, ts1_done, ts2_done;
   logic        seen_ts2_q, up_q;
   logic [TW-1:0] tmr;

   ltrn_lane_agg #(.NUM_LANES(NUM_LANES)) u_agg (
      .sigdet   (rx_sigdet),
      .ts_valid (rx_ts_valid),
      .ts_is_ts2(rx_ts_is_ts2),
      .all_det  (all_det),
      .any_rx   (any_rx),
      .all_rx   (all_rx),
      .all_ts2  (all_ts2)
   );

   assign ts2_now = all_rx & all_ts2;

   ltrn_timer #(.MAX_CYCLES(TMAX)) u_tmr (
      .clk  (clk),
      .rst  (rst),
      .clr  (chg),
      .value(tmr)
   );

   logic rx_inc, rx_miss;
   always_comb begin
      rx_inc  = 1'b0;
      rx_miss = 1'b0;
      if (st_q == ST_POLL) begin
         rx_inc  = all_rx;
         rx_miss = any_rx & ~all_rx;
      end else if (st_q == ST_CFG) begin
         rx_inc  = ts2_now;
         rx_miss = any_rx & ~ts2_now;
      end
   end

   ltrn_sat_cnt #(.LIMIT(RX_NEED)) u_rx_run (
      .clk (clk), .rst(rst), .clr(chg),
      .inc (rx_inc), .miss(1'b0 | rx_miss),
      .done(rx_done)
   );

   ltrn_sat_cnt #(.LIMIT(TS1_TX_NEED)) u_ts1_sent (
      .clk (clk), .rst(rst), .clr(chg),
      .inc (st_q == ST_POLL), .miss(1'b0),
      .done(ts1_done)
   );

   ltrn_sat_cnt #(.LIMIT(TS2_TX_NEED)) u_ts2_sent (
      .clk (clk), .rst(rst), .clr(chg),
      .inc ((st_q == ST_CFG) && (seen_ts2_q || ts2_now)), .miss(1'b0),
      .done(ts2_done)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_QUIET:  if (tmr == TW'(QUIET_CYCLES - 1)) st_d = ST_DETECT;
         ST_DETECT: st_d = all_det ? ST_POLL : ST_QUIET;
         ST_POLL: begin
            if (rx_done && ts1_done)
               st_d = ST_CFG;
            else if (tmr == TW'(POLL_TO_CYCLES - 1))
               st_d = force_compliance ? ST_COMPL : ST_QUIET;
         end
         ST_COMPL:  if (!force_compliance) st_d = ST_POLL;
         ST_CFG: begin
            if (!up_q && !(rx_done && ts2_done) && (tmr == TW'(CFG_TO_CYCLES - 1)))
               st_d = ST_QUIET;
         end
         default:   st_d = ST_QUIET;
      endcase
   end

   assign chg = (st_d != st_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q       <= ST_QUIET;
         seen_ts2_q <= 1'b0;
         up_q       <= 1'b0;
      end else begin
         st_q <= st_d;
         if (chg) begin
            seen_ts2_q <= 1'b0;
            up_q       <= 1'b0;
         end else if (st_q == ST_CFG) begin
            if (ts2_now)              seen_ts2_q <= 1'b1;
            if (rx_done && ts2_done)  up_q       <= 1'b1;
         end
      end
   end

   always_comb begin
      unique case (st_q)
         ST_POLL:  tx_set = TX_TS1;
         ST_CFG:   tx_set = TX_TS2;
         ST_COMPL: tx_set = TX_COMPL;
         default:  tx_set = TX_NONE;
      endcase
   end

   assign dbg_state   = st_q;
   assign link_cfg_up = up_q;
endmodule

// File: rtl/link_train_fsm_chk.sv
module link_train_fsm_chk #(
   parameter int NUM_LANES    = 4,
   parameter int QUIET_CYCLES = 64
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 force_compliance,
   input logic [NUM_LANES-1:0] rx_sigdet,
   input logic [2:0]           dbg_state,
   input logic [1:0]           tx_set,
   input logic                 link_cfg_up
);
   localparam int QW = $clog2(QUIET_CYCLES + 1);

   logic [QW-1:0] quiet_run;

   always_ff @(posedge clk) begin
      if (rst || dbg_state != 3'd0)
         quiet_run <= '0;
      else if (quiet_run != QW'(QUIET_CYCLES))
         quiet_run <= quiet_run + 1'b1;
   end

   p_reset_state_r1: assert property (@(posedge clk)
      rst |=> (dbg_state == 3'd0 && tx_set == 2'd0 && !link_cfg_up));

   p_code_range_r1: assert property (@(posedge clk) disable iff (rst)
      dbg_state <= 3'd4);

   p_quiet_len_r2: assert property (@(posedge clk) disable iff (rst)
      (dbg_state == 3'd0) |-> (quiet_run < QW'(QUIET_CYCLES)));

   p_detect_one_r3: assert property (@(posedge clk) disable iff (rst)
      (dbg_state == 3'd1) |=> (dbg_state == 3'd2 || dbg_state == 3'd0));

   p_detect_pass_r3: assert property (@(posedge clk) disable iff (rst)
      (dbg_state == 3'd1 && (&rx_sigdet)) |=> (dbg_state == 3'd2));

   p_no_compl_r6: assert property (@(posedge clk) disable iff (rst)
      (dbg_state == 3'd2 && !force_compliance) |=> (dbg_state != 3'd3));

   p_compl_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (dbg_state == 3'd3 && force_compliance) |=> (dbg_state == 3'd3));

   p_compl_exit_r7: assert property (@(posedge clk) disable iff (rst)
      (dbg_state == 3'd3 && !force_compliance) |=> (dbg_state == 3'd2));

   p_up_in_cfg_r8: assert property (@(posedge clk) disable iff (rst)
      link_cfg_up |-> (dbg_state == 3'd4 && tx_set == 2'd2));

   p_up_sticky_r8: assert property (@(posedge clk) disable iff (rst)
      link_cfg_up |=> link_cfg_up);

   p_cfg_from_poll_r5: assert property (@(posedge clk) disable iff (rst)
      (dbg_state != 3'd4) |=> (dbg_state != 3'd4 || $past(dbg_state) == 3'd2));
endmodule

bind link_train_fsm link_train_fsm_chk #(
   .NUM_LANES   (NUM_LANES),
   .QUIET_CYCLES(QUIET_CYCLES)
) u_chk (
   .clk             (clk),
   .rst             (rst),
   .force_compliance(force_compliance),
   .rx_sigdet       (rx_sigdet),
   .dbg_state       (dbg_state),
   .tx_set          (tx_set),
   .link_cfg_up     (link_cfg_up)
);

// File: tb/test_link_train_fsm.sv
module test_link_train_fsm;
   localparam int NL   = 4;
   localparam int Q    = 16;
   localparam int PTO  = 200;
   localparam int CTO  = 300;
   localparam int RXN  = 8;
   localparam int TS1N = 32;
   localparam int TS2N = 16;
   localparam logic [NL-1:0] ALL = '1;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          force_compliance = 1'b0;
   logic [NL-1:0] rx_sigdet = '0, rx_ts_valid = '0, rx_ts_is_ts2 = '0;
   logic [2:0]    dbg_state;
   logic [1:0]    tx_set;
   logic          link_cfg_up;

   int checks = 0;
   int errors = 0;
   int n = 0;

   typedef struct {
      int    due;
      int    st;
      int    tx;
      int    up;
      string req;
   } exp_t;
   exp_t sb[$];

   always #10 clk = ~clk;

   always @(posedge clk) begin
      if (rst) n <= 0;
      else     n <= n + 1;
   end

   link_train_fsm #(
      .NUM_LANES(NL), .QUIET_CYCLES(Q), .POLL_TO_CYCLES(PTO),
      .CFG_TO_CYCLES(CTO), .RX_NEED(RXN), .TS1_TX_NEED(TS1N), .TS2_TX_NEED(TS2N)
   ) i_link_train_fsm (
      .clk(clk), .rst(rst), .force_compliance(force_compliance),
      .rx_sigdet(rx_sigdet), .rx_ts_valid(rx_ts_valid), .rx_ts_is_ts2(rx_ts_is_ts2),
      .dbg_state(dbg_state), .tx_set(tx_set), .link_cfg_up(link_cfg_up)
   );

   function automatic int tx_of(input int st);
      case (st)
         2: return 1;
         3: return 3;
         4: return 2;
         default: return 0;
      endcase
   endfunction

   // driver side: push expected state, selector (R4 mapping) and flag
   task automatic expect_at(input int due, input int st, input int up, input string req);
      exp_t e;
      e.due = due; e.st = st; e.tx = tx_of(st); e.up = up; e.req = req;
      sb.push_back(e);
   endtask

   // monitor: compare due items at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         while (!rst && sb.size() > 0 && sb[0].due <= n) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (e.due < n) begin
               errors++;
               $display("FAIL %s: item due at %0d missed (now %0d)", e.req, e.due, n);
            end else if (int'(dbg_state) != e.st || int'(tx_set) != e.tx
                         || int'(link_cfg_up) != e.up) begin
               errors++;
               $display("FAIL %s @%0d: state/tx/up actual %0d/%0d/%0d expected %0d/%0d/%0d",
                        e.req, n, dbg_state, tx_set, link_cfg_up, e.st, e.tx, e.up);
            end
         end
      end
   end

   task automatic wait_n(input int k);
      while (n < k) @(negedge clk);
   endtask

   task automatic drain();
      while (sb.size() > 0) @(negedge clk);
   endtask

   task automatic do_reset(input logic [NL-1:0] det, input logic [NL-1:0] vld,
                           input logic [NL-1:0] ts2, input logic frc);
      @(negedge clk);
      rst = 1'b1;
      rx_sigdet = det; rx_ts_valid = vld; rx_ts_is_ts2 = ts2; force_compliance = frc;
      repeat (3) @(negedge clk);
      checks++;
      if (dbg_state != 3'd0 || tx_set != 2'd0 || link_cfg_up != 1'b0) begin
         errors++;
         $display("FAIL R1 reset: state/tx/up actual %0d/%0d/%0d expected 0/0/0",
                  dbg_state, tx_set, link_cfg_up);
      end
      rst = 1'b0;
   endtask

   initial begin
      automatic int c = Q + TS1N + 2;   // edge count at configuration entry
      automatic int n0;

      // S1: full bring-up (R1..R5, R8)
      do_reset(ALL, ALL, '0, 1'b0);
      expect_at(1,       0, 0, "R1");
      expect_at(Q - 1,   0, 0, "R2");
      expect_at(Q,       1, 0, "R2");
      expect_at(Q + 1,   2, 0, "R3");
      expect_at(c - 1,   2, 0, "R5");
      expect_at(c,       4, 0, "R5");
      expect_at(c + 16,  4, 0, "R8");
      expect_at(c + 17,  4, 1, "R8");
      expect_at(c + CTO + 50, 4, 1, "R8");
      wait_n(c);
      rx_ts_is_ts2 = ALL;      // partner answers TS2 from configuration entry
      drain();

      // S2: one lane without signal detect (R3)
      do_reset(4'b1011, '0, '0, 1'b0);
      expect_at(Q,          1, 0, "R3");
      expect_at(Q + 1,      0, 0, "R3");
      expect_at(2 * Q + 1,  1, 0, "R2");
      drain();

      // S3: silent partner, force clear: cycle back to detect (R6)
      do_reset(ALL, '0, '0, 1'b0);
      expect_at(Q + PTO,         2, 0, "R6");
      expect_at(Q + 1 + PTO,     0, 0, "R6");
      expect_at(2 * Q + 1 + PTO, 1, 0, "R6");
      expect_at(2 * Q + 2 + PTO, 2, 0, "R6");
      drain();

      // S4: silent partner, force set: compliance, then back (R7)
      do_reset(ALL, '0, '0, 1'b1);
      expect_at(Q + 1 + PTO, 3, 0, "R7");
      expect_at(Q + 6 + PTO, 3, 0, "R7");
      expect_at(Q + 7 + PTO, 2, 0, "R7");
      wait_n(Q + 6 + PTO);
      force_compliance = 1'b0;
      drain();

      // S5: partial-lane event breaks the consecutive run (R5)
      do_reset(ALL, '0, '0, 1'b0);
      n0 = Q + 41;
      expect_at(n0 + 9,  2, 0, "R5");
      expect_at(n0 + 16, 2, 0, "R5");
      expect_at(n0 + 17, 4, 0, "R5");
      wait_n(n0);
      rx_ts_valid = ALL;
      wait_n(n0 + 7);
      rx_ts_valid = 4'b0111;
      wait_n(n0 + 8);
      rx_ts_valid = ALL;
      drain();

      // S6: configuration without TS2 times out (R9)
      do_reset(ALL, ALL, '0, 1'b0);
      expect_at(c + CTO - 1, 4, 0, "R9");
      expect_at(c + CTO,     0, 0, "R9");
      drain();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule